// File: doc/BRIEF.md
# 8-bit CPU machine-cycle sequencer

This block is the control sequencer of a small 8-bit accumulator processor. It takes each instruction it fetches and breaks it into machine cycles. Each machine cycle has one of four kinds: opcode fetch, operand read, memory read, or memory write. Each machine cycle is then divided into T states. An opcode fetch takes four T states and every data access takes three. The sequencer drives the address bus, a read strobe, a write strobe, a marker that is high during opcode fetches, and a code that gives the kind of the current machine cycle. It also keeps the program counter, the stack pointer, a temporary address register, and the register pairs that instructions load or store. The current register values are available on output ports, so a host model or a debugger can follow them.

The supported instructions are the following. A one-byte pop into a register pair. A prefixed pop into an index register. A store of the accumulator through HL. A direct store of HL to an absolute address. Any other opcode costs one fetch and has no other effect. The FSM has these states:
- `MC_FETCH1`: the opcode fetch.
- `MC_FETCH2`: the fetch that follows a prefix byte.
- `MC_OPR_LO` / `MC_OPR_HI`: the two operand reads.
- `MC_POP_LO` / `MC_POP_HI`: the two stack reads.
- `MC_WR_ACC`: the accumulator store.
- `MC_WR_LO` / `MC_WR_HI`: the two direct-store writes.

The state changes only on the last T state of a machine cycle. The transitions are:
- FETCH1→FETCH2 on the prefix byte.
- FETCH1→POP_LO on a pop opcode.
- FETCH1→WR_ACC on 77h.
- FETCH1→OPR_LO on 22h.
- FETCH1→FETCH1 on anything else.
- FETCH2→POP_LO when the second byte is E1h, and FETCH2→FETCH1 otherwise.
- POP_LO→POP_HI→FETCH1.
- OPR_LO→OPR_HI→WR_LO→WR_HI→FETCH1.
- WR_ACC→FETCH1.

Top module: `mc_seq`

## Requirements
- R1: An opcode fetch machine cycle lasts exactly 4 T states. During it, `cyc_kind` is 0 and `fetch_mark` is high in all four T states. `rd_stb` is high in T1 and T2 only, and `wr_stb` stays low.
- R2: Every operand read (`cyc_kind` 1), memory read (`cyc_kind` 2) and memory write (`cyc_kind` 3) lasts exactly 3 T states, and `fetch_mark` is low throughout. `rd_stb` is high in T1 and T2 of a read. `wr_stb` is high in T2 and T3 of a write, and `data_out` carries the write data while `wr_stb` is high. The strobes are never high together.
- R3: The program counter increments by one at the end of every opcode fetch and every operand read, and at no other time.
- R4: An opcode of the form 11qq0001b runs as a fetch followed by two memory reads (4,3,3). The pair is selected by qq: 00 is BC, 01 is DE, 10 is HL, 11 is AF, with A as the high byte. The low byte is read from SP and the high byte from SP+1. SP ends two higher and wraps from FFFFh to 0000h.
- R5: The byte pair DDh E1h runs as two fetches from consecutive PC addresses, then two memory reads into IX, low byte first (4,4,3,3). SP behaves as in R4.
- R6: Opcode 77h runs as a fetch then one memory write (4,3). The write puts A on the bus at the address held in HL.
- R7: Opcode 22h runs as a fetch, then two operand reads that load the temporary address low and then high, then two writes (4,3,3,3,3). The writes store L at the temporary address and H at the temporary address plus one.
- R8: Any other opcode is a single 4-T-state fetch that changes nothing except PC. DDh followed by any byte other than E1h is two fetches only.
- R9: While `rst` is high at a clock edge, PC is cleared to 0000h, SP is set to FFFFh, and all register pairs are cleared. The first T state after `rst` falls is T1 of an opcode fetch at address 0000h.
- R10: The address bus holds one value for all T states of a machine cycle. Read data is taken from `data_in` at the clock edge that ends T2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T state |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Read data from memory |
| addr | output | 16 | Address bus |
| data_out | output | 8 | Write data |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| fetch_mark | output | 1 | High throughout opcode fetch cycles |
| cyc_kind | output | 2 | Kind of machine cycle: 0 fetch, 1 operand read, 2 memory read, 3 memory write |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| af_o | output | 16 | Accumulator (high) and low companion byte |
| bc_o | output | 16 | Pair BC |
| de_o | output | 16 | Pair DE |
| hl_o | output | 16 | Pair HL |
| ix_o | output | 16 | Index register |

## Verification
The hardest case to reach is an instruction whose data cycles depend on state left behind by earlier instructions. One example is the accumulator store, which writes through an HL value that a pop loaded. Another is a pop that starts at SP = FFFFh and so wraps into low memory, where the program sits. The stimulus starts from reset with a directed pop at FFFFh. This fills HL from the wrapped stack. A direct store and an accumulator store that use that HL follow. After that comes a long seeded-random instruction stream in which the two operations feed each other. A bench model predicts every machine cycle from the same memory image.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [3:0] {
        MC_FETCH1,
        MC_FETCH2,
        MC_OPR_LO,
        MC_OPR_HI,
        MC_POP_LO,
        MC_POP_HI,
        MC_WR_ACC,
        MC_WR_LO,
        MC_WR_HI
    } mc_state_e;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_OPRD  = 2'd1,
        KIND_MEMRD = 2'd2,
        KIND_MEMWR = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        CLS_NOP,
        CLS_PREFIX,
        CLS_POP,
        CLS_ST_ACC,
        CLS_ST_HL
    } op_class_e;

    typedef enum logic [2:0] {
        DST_BC = 3'd0,
        DST_DE = 3'd1,
        DST_HL = 3'd2,
        DST_AF = 3'd3,
        DST_IX = 3'd4
    } dst_e;

    typedef enum logic [2:0] {
        LD_NONE,
        LD_DST_LO,
        LD_DST_HI,
        LD_TMP_LO,
        LD_TMP_HI
    } ld_sel_e;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
    import mc_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] OP_PREFIX = 8'hDD,
    parameter logic [DATA_W-1:0] OP_POP_IX = 8'hE1,
    parameter logic [DATA_W-1:0] OP_ST_ACC = 8'h77,
    parameter logic [DATA_W-1:0] OP_ST_HL  = 8'h22,
    parameter logic [DATA_W-1:0] POP_MASK  = 8'hCF,
    parameter logic [DATA_W-1:0] POP_MATCH = 8'hC1,
    parameter int                PAIR_LSB  = 4
) (
    input  logic [DATA_W-1:0] opcode,
    input  logic              second,
    output op_class_e         cls,
    output dst_e              dst
);

    always_comb begin
        cls = CLS_NOP;
        dst = DST_BC;
        if (second) begin
            if (opcode == OP_POP_IX) begin
                cls = CLS_POP;
                dst = DST_IX;
            end
        end else if (opcode == OP_PREFIX) begin
            cls = CLS_PREFIX;
        end else if (opcode == OP_ST_ACC) begin
            cls = CLS_ST_ACC;
        end else if (opcode == OP_ST_HL) begin
            cls = CLS_ST_HL;
        end else if ((opcode & POP_MASK) == POP_MATCH) begin
            cls = CLS_POP;
            dst = dst_e'({1'b0, opcode[PAIR_LSB +: 2]});
        end
    end

endmodule

// File: rtl/mc_tcount.sv
module mc_tcount #(
    parameter int FETCH_T = 4,
    parameter int DATA_T  = 3,
    parameter int TW      = $clog2(FETCH_T)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          is_fetch,
    output logic [TW-1:0] t_q,
    output logic          t_last
);

    localparam logic [TW-1:0] FETCH_END = TW'(FETCH_T - 1);
    localparam logic [TW-1:0] DATA_END  = TW'(DATA_T - 1);

    assign t_last = is_fetch ? (t_q == FETCH_END) : (t_q == DATA_END);

    always_ff @(posedge clk) begin
        if (rst)         t_q <= '0;
        else if (t_last) t_q <= '0;
        else             t_q <= t_q + 1'b1;
    end

    // R1: a fetch wraps its T count after the fourth state
    assert_fetch_len_R1: assert property (@(posedge clk) disable iff (rst)
        (is_fetch && t_q == FETCH_END) |=> (t_q == '0));

    // R2: a data access wraps after its third state
    assert_data_len_R2: assert property (@(posedge clk) disable iff (rst)
        (!is_fetch && t_q == DATA_END) |=> (t_q == '0));

endmodule

// File: rtl/mc_regs.sv
module mc_regs
    import mc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              pc_inc,
    input  logic              sp_inc,
    input  ld_sel_e           ld_sel,
    input  dst_e              dst,
    output logic [PAIR_W-1:0] pc,
    output logic [PAIR_W-1:0] sp,
    output logic [PAIR_W-1:0] tmp,
    output logic [PAIR_W-1:0] af,
    output logic [PAIR_W-1:0] bc,
    output logic [PAIR_W-1:0] de,
    output logic [PAIR_W-1:0] hl,
    output logic [PAIR_W-1:0] ix
);

    localparam int NPAIR = 5;

    logic [PAIR_W-1:0] pair_q [NPAIR];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            sp  <= '1;
            tmp <= '0;
        end else begin
            if (pc_inc) pc <= pc + 1'b1;
            if (sp_inc) sp <= sp + 1'b1;
            if (ld_sel == LD_TMP_LO) tmp[DATA_W-1:0]      <= din;
            if (ld_sel == LD_TMP_HI) tmp[PAIR_W-1:DATA_W] <= din;
        end
    end

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                pair_q[i] <= '0;
            end else if (dst == dst_e'(3'(i))) begin
                if (ld_sel == LD_DST_LO) pair_q[i][DATA_W-1:0]      <= din;
                if (ld_sel == LD_DST_HI) pair_q[i][PAIR_W-1:DATA_W] <= din;
            end
        end
    end

    assign bc = pair_q[DST_BC];
    assign de = pair_q[DST_DE];
    assign hl = pair_q[DST_HL];
    assign af = pair_q[DST_AF];
    assign ix = pair_q[DST_IX];

    // R3: the program counter advances by exactly one when told to
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        pc_inc |=> (pc == $past(pc) + 1'b1));

    // R3: without a step request the program counter holds
    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!pc_inc && !$past(rst)) |=> (pc == $past(pc)));

    // R4: every stack read advances SP by one
    assert_sp_step_R4: assert property (@(posedge clk) disable iff (rst)
        sp_inc |=> (sp == $past(sp) + 1'b1));

endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                FETCH_T   = 4,
    parameter int                DATA_T    = 3,
    parameter logic [DATA_W-1:0] OP_PREFIX = 8'hDD,
    parameter logic [DATA_W-1:0] OP_POP_IX = 8'hE1,
    parameter logic [DATA_W-1:0] OP_ST_ACC = 8'h77,
    parameter logic [DATA_W-1:0] OP_ST_HL  = 8'h22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   data_in,
    output logic [2*DATA_W-1:0] addr,
    output logic [DATA_W-1:0]   data_out,
    output logic                rd_stb,
    output logic                wr_stb,
    output logic                fetch_mark,
    output logic [1:0]          cyc_kind,
    output logic [2*DATA_W-1:0] pc_o,
    output logic [2*DATA_W-1:0] sp_o,
    output logic [2*DATA_W-1:0] af_o,
    output logic [2*DATA_W-1:0] bc_o,
    output logic [2*DATA_W-1:0] de_o,
    output logic [2*DATA_W-1:0] hl_o,
    output logic [2*DATA_W-1:0] ix_o
);

    localparam int            ADDR_W   = 2 * DATA_W;
    localparam int            TW       = $clog2(FETCH_T);
    localparam logic [TW-1:0] T_SAMPLE = TW'(1);
    localparam logic [TW-1:0] T_WR_ON  = TW'(1);
    localparam logic [TW-1:0] T_WR_OFF = TW'(DATA_T - 1);

    mc_state_e         state_q, state_d;
    logic [TW-1:0]     t_q;
    logic              t_last, is_fetch, in_second;
    logic [DATA_W-1:0] ir_q;
    op_class_e         dec_cls;
    dst_e              dec_dst, dst_q;
    ld_sel_e           ld_sel;
    cyc_kind_e         kind;
    logic              pc_inc, sp_inc;
    logic [ADDR_W-1:0] pc, sp, tmp, af, bc, de, hl, ix;

    assign is_fetch  = (state_q == MC_FETCH1) || (state_q == MC_FETCH2);
    assign in_second = (state_q == MC_FETCH2);

    mc_tcount #(.FETCH_T(FETCH_T), .DATA_T(DATA_T), .TW(TW)) u_tcount (
        .clk(clk), .rst(rst), .is_fetch(is_fetch), .t_q(t_q), .t_last(t_last)
    );

    mc_decode #(
        .DATA_W(DATA_W), .OP_PREFIX(OP_PREFIX), .OP_POP_IX(OP_POP_IX),
        .OP_ST_ACC(OP_ST_ACC), .OP_ST_HL(OP_ST_HL)
    ) u_decode (
        .opcode(ir_q), .second(in_second), .cls(dec_cls), .dst(dec_dst)
    );

    mc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .din(data_in), .pc_inc(pc_inc), .sp_inc(sp_inc),
        .ld_sel(ld_sel), .dst(dst_q), .pc(pc), .sp(sp), .tmp(tmp),
        .af(af), .bc(bc), .de(de), .hl(hl), .ix(ix)
    );

    // state register: advance only on the last T state of a machine cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MC_FETCH1;
            ir_q    <= '0;
            dst_q   <= DST_BC;
        end else begin
            if (is_fetch && t_q == T_SAMPLE) ir_q <= data_in;
            if (is_fetch && t_last)          dst_q <= dec_dst;
            if (t_last)                      state_q <= state_d;
        end
    end

    // next machine cycle
    always_comb begin
        state_d = MC_FETCH1;
        unique case (state_q)
            MC_FETCH1: begin
                unique case (dec_cls)
                    CLS_PREFIX: state_d = MC_FETCH2;
                    CLS_POP:    state_d = MC_POP_LO;
                    CLS_ST_ACC: state_d = MC_WR_ACC;
                    CLS_ST_HL:  state_d = MC_OPR_LO;
                    default:    state_d = MC_FETCH1;
                endcase
            end
            MC_FETCH2: state_d = (dec_cls == CLS_POP) ? MC_POP_LO : MC_FETCH1;
            MC_POP_LO: state_d = MC_POP_HI;
            MC_POP_HI: state_d = MC_FETCH1;
            MC_OPR_LO: state_d = MC_OPR_HI;
            MC_OPR_HI: state_d = MC_WR_LO;
            MC_WR_LO:  state_d = MC_WR_HI;
            MC_WR_HI:  state_d = MC_FETCH1;
            MC_WR_ACC: state_d = MC_FETCH1;
            default:   state_d = MC_FETCH1;
        endcase
    end

    // bus and register-control outputs
    always_comb begin
        kind       = KIND_FETCH;
        addr       = pc;
        rd_stb     = 1'b0;
        wr_stb     = 1'b0;
        fetch_mark = 1'b0;
        data_out   = '0;
        ld_sel     = LD_NONE;
        pc_inc     = 1'b0;
        sp_inc     = 1'b0;
        unique case (state_q)
            MC_FETCH1, MC_FETCH2: begin
                fetch_mark = 1'b1;
                rd_stb     = (t_q <= T_SAMPLE);
                pc_inc     = t_last;
            end
            MC_OPR_LO, MC_OPR_HI: begin
                kind   = KIND_OPRD;
                rd_stb = (t_q <= T_SAMPLE);
                pc_inc = t_last;
                if (t_q == T_SAMPLE)
                    ld_sel = (state_q == MC_OPR_LO) ? LD_TMP_LO : LD_TMP_HI;
            end
            MC_POP_LO, MC_POP_HI: begin
                kind   = KIND_MEMRD;
                addr   = sp;
                rd_stb = (t_q <= T_SAMPLE);
                sp_inc = t_last;
                if (t_q == T_SAMPLE)
                    ld_sel = (state_q == MC_POP_LO) ? LD_DST_LO : LD_DST_HI;
            end
            MC_WR_ACC: begin
                kind     = KIND_MEMWR;
                addr     = hl;
                wr_stb   = (t_q >= T_WR_ON) && (t_q <= T_WR_OFF);
                data_out = af[ADDR_W-1:DATA_W];
            end
            MC_WR_LO: begin
                kind     = KIND_MEMWR;
                addr     = tmp;
                wr_stb   = (t_q >= T_WR_ON) && (t_q <= T_WR_OFF);
                data_out = hl[DATA_W-1:0];
            end
            MC_WR_HI: begin
                kind     = KIND_MEMWR;
                addr     = tmp + 1'b1;
                wr_stb   = (t_q >= T_WR_ON) && (t_q <= T_WR_OFF);
                data_out = hl[ADDR_W-1:DATA_W];
            end
            default: ;
        endcase
    end

    assign cyc_kind = kind;
    assign pc_o = pc;
    assign sp_o = sp;
    assign af_o = af;
    assign bc_o = bc;
    assign de_o = de;
    assign hl_o = hl;
    assign ix_o = ix;

    // R2: read and write strobes never overlap
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    // R1: the fetch marker never accompanies a write
    assert_fetch_no_wr_R1: assert property (@(posedge clk) disable iff (rst)
        fetch_mark |-> !wr_stb);

    // R10: the address holds until the machine cycle ends
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!t_last) |=> $stable(addr));

    // R9: the first state after reset is a fetch at PC
    assert_reset_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fetch_mark && addr == pc));

endmodule

// File: tb/mc_seq_test.sv
module mc_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] addr, pc_o, sp_o, af_o, bc_o, de_o, hl_o, ix_o;
    logic [7:0]  data_out;
    logic        rd_stb, wr_stb, fetch_mark;
    logic [1:0]  cyc_kind;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0]  mem [int];
    logic [15:0] m_pc, m_sp, m_af, m_bc, m_de, m_hl, m_ix;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_seq uut (
        .clk(clk), .rst(rst), .data_in(data_in), .addr(addr), .data_out(data_out),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .fetch_mark(fetch_mark), .cyc_kind(cyc_kind),
        .pc_o(pc_o), .sp_o(sp_o), .af_o(af_o), .bc_o(bc_o), .de_o(de_o),
        .hl_o(hl_o), .ix_o(ix_o)
    );

    function automatic logic [7:0] memrd(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected {kind, fetch_mark, rd, wr, addr} in T index i of a cycle
    function automatic logic [20:0] exp_bus(input int kind, input int i, input logic [15:0] a);
        logic fm, rd, wr;
        fm = (kind == 0);
        rd = (kind != 3) && (i <= 1);
        wr = (kind == 3) && (i >= 1) && (i <= 2);
        return {2'(kind), fm, rd, wr, a};
    endfunction

    // one machine cycle: R1 for fetches, R2 for data cycles, R10 for address hold
    task automatic mcycle(input int kind, input logic [15:0] a, input logic [7:0] wdat);
        int n;
        logic [20:0] act, exp;
        n = (kind == 0) ? 4 : 3;
        for (int i = 0; i < n; i++) begin
            if (kind != 3) data_in = memrd(a);
            exp = exp_bus(kind, i, a);
            act = {cyc_kind, fetch_mark, rd_stb, wr_stb, addr};
            chk(act == exp, (kind == 0) ? "R1" : "R2", "bus", 32'(act), 32'(exp));
            if (kind == 3 && i == 1) begin
                chk(data_out == wdat, "R2", "wdata", 32'(data_out), 32'(wdat));
                mem[int'(a)] = wdat;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_regs(input string req);
        chk(pc_o == m_pc, req, "pc", 32'(pc_o), 32'(m_pc));
        chk(sp_o == m_sp, req, "sp", 32'(sp_o), 32'(m_sp));
        chk({af_o, bc_o} == {m_af, m_bc}, req, "af:bc", {af_o, bc_o}, {m_af, m_bc});
        chk({de_o, hl_o} == {m_de, m_hl}, req, "de:hl", {de_o, hl_o}, {m_de, m_hl});
        chk(ix_o == m_ix, req, "ix", 32'(ix_o), 32'(m_ix));
    endtask

    task automatic do_pop(input int qq);
        logic [7:0] lo, hi;
        lo = memrd(m_sp); mcycle(2, m_sp, 8'h00); m_sp++;
        hi = memrd(m_sp); mcycle(2, m_sp, 8'h00); m_sp++;
        case (qq)
            0: m_bc = {hi, lo};
            1: m_de = {hi, lo};
            2: m_hl = {hi, lo};
            3: m_af = {hi, lo};
            default: m_ix = {hi, lo};
        endcase
    endtask

    task automatic run_instr();
        logic [7:0] op, op2, lo, hi;
        logic [15:0] t;
        string req;
        op = memrd(m_pc); mcycle(0, m_pc, 8'h00); m_pc++;
        if (op == 8'hDD) begin
            op2 = memrd(m_pc); mcycle(0, m_pc, 8'h00); m_pc++;
            if (op2 == 8'hE1) begin do_pop(4); req = "R5"; end
            else req = "R8";
        end else if (op == 8'h77) begin
            mcycle(3, m_hl, m_af[15:8]); req = "R6";
        end else if (op == 8'h22) begin
            lo = memrd(m_pc); mcycle(1, m_pc, 8'h00); m_pc++;
            hi = memrd(m_pc); mcycle(1, m_pc, 8'h00); m_pc++;
            t = {hi, lo};
            mcycle(3, t, m_hl[7:0]);
            mcycle(3, t + 16'd1, m_hl[15:8]);
            req = "R7";
        end else if ((op & 8'hCF) == 8'hC1) begin
            do_pop(int'(op[5:4])); req = "R4";
        end else begin
            req = "R8";
        end
        check_regs(req);
        chk(pc_o == m_pc, "R3", "pc", 32'(pc_o), 32'(m_pc));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(pc_o == 16'h0000 && sp_o == 16'hFFFF, "R9", "pc:sp", {pc_o, sp_o}, 32'h0000FFFF);
        chk({af_o, bc_o, de_o, hl_o, ix_o} == '0, "R9", "pairs", 32'(hl_o), 32'h0);
        m_pc = 16'h0000; m_sp = 16'hFFFF;
        m_af = '0; m_bc = '0; m_de = '0; m_hl = '0; m_ix = '0;
        rst = 1'b0;
        // first sample is T1 of the fetch at 0000h (R9)
        chk(fetch_mark && addr == 16'h0000, "R9", "first fetch", 32'({fetch_mark, addr}), 32'h10000);
    endtask

    function automatic logic [7:0] plain_op();
        logic [7:0] b;
        do b = 8'($urandom_range(0, 255));
        while (b == 8'hDD || b == 8'h77 || b == 8'h22 || (b & 8'hCF) == 8'hC1);
        return b;
    endfunction

    task automatic build_program();
        int p;
        int c;
        logic [15:0] t;
        logic [7:0] b;
        mem[32'hFFFF] = 8'h34;
        // directed: pop HL across the FFFFh wrap, store HL direct, store A
        mem[0] = 8'hE1; mem[1] = 8'h22; mem[2] = 8'h00; mem[3] = 8'h90; mem[4] = 8'h77;
        p = 5;
        for (int k = 0; k < N_RAND; k++) begin
            c = $urandom_range(0, 7);
            case (c)
                0, 1, 7: begin mem[p] = 8'hC1 | 8'($urandom_range(0, 3) << 4); p++; end
                2: begin mem[p] = 8'hDD; mem[p+1] = 8'hE1; p += 2; end
                3: begin mem[p] = 8'h77; p++; end
                4: begin
                    t = 16'h8000 | 16'($urandom_range(0, 254));
                    mem[p] = 8'h22; mem[p+1] = t[7:0]; mem[p+2] = t[15:8]; p += 3;
                end
                5: begin mem[p] = plain_op(); p++; end
                default: begin
                    do b = 8'($urandom_range(0, 255)); while (b == 8'hE1);
                    mem[p] = 8'hDD; mem[p+1] = b; p += 2;
                end
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        build_program();
        @(negedge clk);
        do_reset();
        run_instr();
        chk(hl_o == 16'hE134, "R4", "wrapped pop", 32'(hl_o), 32'hE134);
        chk(sp_o == 16'h0001, "R4", "sp wrap", 32'(sp_o), 32'h0001);
        run_instr();
        chk({memrd(16'h9001), memrd(16'h9000)} == 16'hE134, "R7", "direct store",
            32'({memrd(16'h9001), memrd(16'h9000)}), 32'hE134);
        run_instr();
        for (int k = 0; k < N_RAND; k++) run_instr();
        // reset in mid-stream, then run again from 0000h
        do_reset();
        for (int k = 0; k < 20; k++) run_instr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule